// File: doc/BRIEF.md
# Signed-Digit Magnitude Comparator

This block compares two operands held in redundant radix-2 signed-digit form. It reports whether A is numerically equal to, greater than or less than B. Each operand has N digits. Every digit takes one of the values -1, 0 or +1, so one value can be written as several different digit strings. The relation is therefore decided on the numbers the strings stand for, never on their raw bit patterns.

The block is purely combinational and has two stages.

- **First stage.** Each digit position works on its own. It negates the digit of B and forms a carry-free signed-digit difference D = A - B. Each position then classifies its digit of D as positive, negative or zero. A transfer only ever moves one position up.
- **Second stage.** A combining network scans the per-position flags. The most significant nonzero digit of D decides the answer.

A reserved digit code is reported on a separate error output, and that case silences all three relation outputs. The block is meant to sit in a datapath that keeps its values in redundant form, such as an arithmetic unit that avoids carry chains.

Top module: `sd_compare`

## Requirements
- R1: Digit i of an operand occupies bits [2i+1:2i]. The code 01 means +1, 11 means -1 and 00 means 0. The value of an operand is the sum of digit_i times 2^i. When value(A) > value(B), `gt_o` is 1.
- R2: When value(A) < value(B), `lt_o` is 1.
- R3: When value(A) = value(B), `eq_o` is 1. This holds even when the two digit strings differ, and it includes the all-zero operands.
- R4: For any pair of operands with no reserved code, exactly one of `eq_o`, `gt_o` and `lt_o` is 1, and `err_o` is 0.
- R5: If the reserved code 10 appears in any digit of either operand, `err_o` is 1 and `eq_o`, `gt_o` and `lt_o` are all 0.
- R6: Digit N-1 carries the largest weight. When the top digit of A is +1 and the top digit of B is -1, `gt_o` is 1 whatever the lower digits are. When the two top digits are the other way round, `lt_o` is 1.
- R7: The outputs depend on the present inputs only. No clock or stored state is involved, so the outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_digits | input | 2*N | Operand A, N two-bit digit codes, digit 0 in the low bits |
| b_digits | input | 2*N | Operand B, same layout as A |
| eq_o | output | 1 | A equals B in value |
| gt_o | output | 1 | A is greater than B in value |
| lt_o | output | 1 | A is less than B in value |
| err_o | output | 1 | A reserved digit code is present on either operand |

## Verification
The block holds no state, so any fault in a transfer, an interim digit or the merge chain shows up at once. It appears as a wrong or non-one-hot relation for the very input pair that exercises it. With four digits, every one of the 65,536 code combinations of the two operands is applied. This covers every valid pair, including all the equal-value pairs whose strings differ, as well as every placement of the reserved code. Each result is compared with integer arithmetic on the digit weights. A wrong transfer choice at one position therefore shows up as a relation error for the operand pairs that need that choice.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

  localparam logic [1:0] CODE_ZERO = 2'b00;
  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_BAD  = 2'b10;
  localparam logic [1:0] CODE_NEG  = 2'b11;

  // signed digit value, wide enough for a position sum in -2..+2
  typedef logic signed [2:0] dval_t;

  typedef struct packed {
    logic pos;
    logic neg;
  } dsign_t;

  function automatic dval_t code_value(input logic [1:0] code);
    dval_t v;
    case (code)
      CODE_POS: v = 3'sd1;
      CODE_NEG: v = -3'sd1;
      default:  v = 3'sd0;
    endcase
    return v;
  endfunction

  function automatic logic code_ok(input logic [1:0] code);
    return code != CODE_BAD;
  endfunction

endpackage

// File: rtl/sdc_pos_cell.sv
`timescale 1ns/1ps
// One position of the carry-free difference A - B.
// Splits the position sum into a transfer to the next position up and an
// interim digit, chosen by the sign class of the position below so that
// interim + incoming transfer stays inside {-1,0,+1}.
module sdc_pos_cell
  import sdc_pkg::*;
(
  input  logic [1:0] a_code,
  input  logic [1:0] b_code,
  input  logic       lower_nonneg,
  output dval_t      xfer,
  output dval_t      interim,
  output logic       nonneg
);

  dval_t psum;

  always_comb begin
    psum = code_value(a_code) - code_value(b_code);
    case (psum)
      3'sd2: begin
        xfer    = 3'sd1;
        interim = 3'sd0;
      end
      3'sd1: begin
        if (lower_nonneg) begin
          xfer    = 3'sd1;
          interim = -3'sd1;
        end else begin
          xfer    = 3'sd0;
          interim = 3'sd1;
        end
      end
      3'sd0: begin
        xfer    = 3'sd0;
        interim = 3'sd0;
      end
      -3'sd1: begin
        if (lower_nonneg) begin
          xfer    = 3'sd0;
          interim = -3'sd1;
        end else begin
          xfer    = -3'sd1;
          interim = 3'sd1;
        end
      end
      default: begin
        xfer    = -3'sd1;
        interim = 3'sd0;
      end
    endcase
  end

  // both addends (a and negated b) non-negative
  assign nonneg = (a_code != CODE_NEG) && (b_code != CODE_POS);

endmodule

// File: rtl/sdc_digit_class.sv
`timescale 1ns/1ps
// Sign flags of one final difference digit.
module sdc_digit_class
  import sdc_pkg::*;
(
  input  dval_t  dig,
  output dsign_t sgn
);

  always_comb begin
    sgn.neg = dig[2];
    sgn.pos = !dig[2] && (dig != 3'sd0);
  end

endmodule

// File: rtl/sdc_merge.sv
`timescale 1ns/1ps
// Combining stage: the highest nonzero position decides the relation.
module sdc_merge
  import sdc_pkg::*;
#(
  parameter int W = 5
) (
  input  dsign_t [W-1:0] sgn,
  output logic           pos_o,
  output logic           neg_o
);

  dsign_t [W-1:0] acc;

  assign acc[0] = sgn[0];

  for (genvar i = 1; i < W; i++) begin : g_chain
    assign acc[i] = (sgn[i].pos || sgn[i].neg) ? sgn[i] : acc[i-1];
  end

  assign pos_o = acc[W-1].pos;
  assign neg_o = acc[W-1].neg;

endmodule

// File: rtl/sd_compare.sv
`timescale 1ns/1ps
module sd_compare
  import sdc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] a_digits,
  input  logic [2*N-1:0] b_digits,
  output logic           eq_o,
  output logic           gt_o,
  output logic           lt_o,
  output logic           err_o
);

  localparam int DW = N + 1;  // difference digits incl. top transfer

  dval_t          xfer    [N];
  dval_t          interim [N];
  dval_t          dig     [DW];
  logic [N-1:0]   nn;
  logic [N-1:0]   code_good;
  dsign_t [DW-1:0] sgn;
  logic           rel_pos;
  logic           rel_neg;

  for (genvar i = 0; i < N; i++) begin : g_pos
    logic lower_nn;
    if (i == 0) begin : g_lsb
      assign lower_nn = 1'b1;
      assign dig[i]   = interim[i];
    end else begin : g_upper
      assign lower_nn = nn[i-1];
      assign dig[i]   = interim[i] + xfer[i-1];
    end

    sdc_pos_cell u_cell (
      .a_code       (a_digits[2*i+1:2*i]),
      .b_code       (b_digits[2*i+1:2*i]),
      .lower_nonneg (lower_nn),
      .xfer         (xfer[i]),
      .interim      (interim[i]),
      .nonneg       (nn[i])
    );

    assign code_good[i] = code_ok(a_digits[2*i+1:2*i]) &&
                          code_ok(b_digits[2*i+1:2*i]);
  end

  assign dig[N] = xfer[N-1];

  for (genvar j = 0; j < DW; j++) begin : g_cls
    sdc_digit_class u_cls (
      .dig (dig[j]),
      .sgn (sgn[j])
    );
  end

  sdc_merge #(.W(DW)) u_merge (
    .sgn   (sgn),
    .pos_o (rel_pos),
    .neg_o (rel_neg)
  );

  assign err_o = !(&code_good);
  assign gt_o  = !err_o && rel_pos;
  assign lt_o  = !err_o && rel_neg;
  assign eq_o  = !err_o && !rel_pos && !rel_neg;

endmodule

// File: rtl/sd_compare_chk.sv
`timescale 1ns/1ps
module sd_compare_chk
  import sdc_pkg::*;
#(
  parameter int N = 4
) (
  input logic [2*N-1:0] a_digits,
  input logic [2*N-1:0] b_digits,
  input logic           eq_o,
  input logic           gt_o,
  input logic           lt_o,
  input logic           err_o
);

  logic [1:0] a_top;
  logic [1:0] b_top;
  logic       known;

  always_comb begin
    a_top = a_digits[2*N-1 -: 2];
    b_top = b_digits[2*N-1 -: 2];
    known = !$isunknown({a_digits, b_digits, eq_o, gt_o, lt_o, err_o});
    if (known) begin
      assert_onehot_R4: assert (err_o || $onehot({eq_o, gt_o, lt_o}))
        else $error("relation outputs not one-hot");
      assert_err_quiet_R5: assert (!err_o || !(eq_o || gt_o || lt_o))
        else $error("relation output high with error");
      assert_same_equal_R3: assert (err_o || (a_digits != b_digits) || eq_o)
        else $error("identical operands not equal");
      assert_top_gt_R6: assert (err_o || !(a_top == CODE_POS && b_top == CODE_NEG) || gt_o)
        else $error("top digit +1 vs -1 not greater");
      assert_top_lt_R2: assert (err_o || !(a_top == CODE_NEG && b_top == CODE_POS) || lt_o)
        else $error("top digit -1 vs +1 not less");
    end
  end

endmodule

bind sd_compare sd_compare_chk #(.N(N)) u_chk (.*);

// File: tb/sd_compare_tb.sv
`timescale 1ns/1ps
module sd_compare_tb;

  localparam int N = 4;

  logic           clk;
  logic [2*N-1:0] a_digits;
  logic [2*N-1:0] b_digits;
  logic           eq_o, gt_o, lt_o, err_o;
  int             total;
  int             fails;
  bit             done;

  sd_compare #(.N(N)) u_dut (
    .a_digits (a_digits),
    .b_digits (b_digits),
    .eq_o     (eq_o),
    .gt_o     (gt_o),
    .lt_o     (lt_o),
    .err_o    (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // R1 weights: code 01 = +1, 11 = -1, 00 = 0, digit i weight 2^i
  function automatic int value_of(input logic [2*N-1:0] c);
    int v = 0;
    for (int i = 0; i < N; i++) begin
      if (c[2*i +: 2] == 2'b01) v += (1 << i);
      else if (c[2*i +: 2] == 2'b11) v -= (1 << i);
    end
    return v;
  endfunction

  function automatic bit has_bad(input logic [2*N-1:0] c);
    for (int i = 0; i < N; i++)
      if (c[2*i +: 2] == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  // {err, eq, gt, lt}
  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%b b=%b got {err,eq,gt,lt}=%b expected %b",
               req, a_digits, b_digits, got, exp);
    end
  endtask

  task automatic apply(input logic [2*N-1:0] a, input logic [2*N-1:0] b);
    @(posedge clk);
    a_digits = a;
    b_digits = b;
    @(negedge clk);
  endtask

  function automatic logic [3:0] expect_of(input logic [2*N-1:0] a, input logic [2*N-1:0] b);
    int va, vb;
    if (has_bad(a) || has_bad(b)) return 4'b1000;
    va = value_of(a);
    vb = value_of(b);
    if (va == vb) return 4'b0100;
    if (va > vb)  return 4'b0010;
    return 4'b0001;
  endfunction

  initial begin
    total = 0;
    fails = 0;
    done  = 1'b0;
    a_digits = '0;
    b_digits = '0;
    @(negedge clk);
    check("R3 zero operands at start", {err_o, eq_o, gt_o, lt_o}, 4'b0100);

    // R6 top digit dominates: 8 vs 7
    apply(8'b01_00_00_00, 8'b00_01_01_01);
    check("R6 top +1 beats lower digits", {err_o, eq_o, gt_o, lt_o}, 4'b0010);
    // R6 top +1 vs top -1 with lower digits pulling the other way
    apply(8'b01_11_11_11, 8'b11_01_01_01);
    check("R6 top +1 vs top -1", {err_o, eq_o, gt_o, lt_o}, 4'b0010);
    // R3 different strings, same value: 8-4-2-1 = 1
    apply(8'b01_11_11_11, 8'b00_00_00_01);
    check("R3 redundant equal strings", {err_o, eq_o, gt_o, lt_o}, 4'b0100);
    // R5 reserved code in lowest digit of B only
    apply(8'b00_00_00_00, 8'b00_00_00_10);
    check("R5 reserved code in B", {err_o, eq_o, gt_o, lt_o}, 4'b1000);

    // R7 outputs follow input change without a clock edge
    a_digits = 8'b11_00_00_00;
    b_digits = 8'b00_00_00_00;
    #1;
    check("R7 combinational response lt", {err_o, eq_o, gt_o, lt_o}, 4'b0001);
    a_digits = 8'b00_00_00_01;
    #1;
    check("R7 combinational response gt", {err_o, eq_o, gt_o, lt_o}, 4'b0010);

    // exhaustive sweep over every code pattern of both operands
    for (int k = 0; k < (1 << (4*N)); k++) begin
      logic [2*N-1:0] ka;
      logic [2*N-1:0] kb;
      logic [3:0]     ex;
      ka = k[4*N-1:2*N];
      kb = k[2*N-1:0];
      apply(ka, kb);
      ex = expect_of(ka, kb);
      case (ex)
        4'b1000: check("R5 reserved code", {err_o, eq_o, gt_o, lt_o}, ex);
        4'b0100: check("R3 equal value", {err_o, eq_o, gt_o, lt_o}, ex);
        4'b0010: check("R1 greater value", {err_o, eq_o, gt_o, lt_o}, ex);
        default: check("R2 less value", {err_o, eq_o, gt_o, lt_o}, ex);
      endcase
      if (!ex[3])
        check("R4 one relation only", {err_o, 2'b00, ($countones({eq_o, gt_o, lt_o}) == 1)}, 4'b0001);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired before sweep completed");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule